// File: doc/BRIEF.md
# Doorbell-and-Payload Acknowledge Sequencer

This block sits on the receiving side of an inter-processor mailbox. It sends one acknowledgement to the peer, and only when two things are both true. The peer must have rung the doorbell, which is bit 0 of the peer's flag register. The DMA payload tied to that doorbell must also have fully landed, which a level input reports. Until then the block keeps polling the peer's flag register through a single-outstanding read port. Each poll waits for its read-valid response before the flag is evaluated.

When both conditions hold, the sequencer fetches the peer's command word. It echoes that word into its own command register and then writes the acknowledge value into its own flag register. It then parks in a terminal done state. Reads and writes use one shared address bus. The acknowledge counter reports how many acknowledgements were sent, so it ends at exactly one. The mailbox register file and the DMA engine are outside this block.

Top module: `mbx_ack_sequencer`

## Requirements
- R1: While reset is held, `done` is 0, `ack_cnt` is 0 and neither `mbx_rd_en` nor `mbx_wr_en` is asserted. In the first cycle after reset is released, a poll read is requested at offset 0x30.
- R2: A poll is a one-cycle read request at offset 0x30 (peer flag). No further read is requested until `mbx_rd_valid` has returned the previous one, and polling repeats as long as the acknowledge conditions fail.
- R3: A poll response with bit 0 set (doorbell) while `payload_done` is low causes no write, leaves `ack_cnt` at 0 and `done` at 0, and the block polls again.
- R4: While `payload_done` is high, a poll response with bit 0 clear causes no write and leaves `ack_cnt` at 0. No write is ever issued while `payload_done` is low.
- R5: When a poll response has bit 0 set and `payload_done` is high in that response's cycle, exactly one read of offset 0x10 (peer command) follows. Its full returned word is then written to offset 0x00 (own command). In the next cycle the value 0x2 is written to offset 0x20 (own flag).
- R6: A read and a write are never requested in the same cycle. Reads target only 0x30 or 0x10, and writes target only 0x00 or 0x20.
- R7: `done` rises in the cycle after the acknowledge-flag write and then stays high until reset. `ack_cnt` then holds 1, and no further read or write is requested.
- R8: `payload_done` is treated as a level, so the acknowledgement happens whether it rises before or after the doorbell appears.
- R9: `payload_done` rising in the same cycle as the `mbx_rd_valid` that returns the doorbell counts for that poll: no extra poll is issued before the command fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mbx_rd_en | output | 1 | Mailbox read request, one cycle per read |
| mbx_wr_en | output | 1 | Mailbox write strobe |
| mbx_addr | output | ADDR_W | Shared read/write register offset |
| mbx_wr_data | output | DATA_W | Write data |
| mbx_rd_data | input | DATA_W | Read data, qualified by `mbx_rd_valid` |
| mbx_rd_valid | input | 1 | Read response valid, at least one cycle after the request |
| payload_done | input | 1 | Level: the DMA payload has fully arrived |
| done | output | 1 | Terminal state reached, acknowledgement sent |
| ack_cnt | output | CNT_W | Number of acknowledgements sent |

## Verification
The delicate coincidence is the payload-complete level rising in the same cycle that a poll response carries the doorbell. The bench's mailbox model raises `payload_done` on exactly the clock phase in which it drives the doorbell-bearing `mbx_rd_valid` for a chosen poll number. It then judges the outcome by the poll count: the sequencer must go straight to the command fetch without issuing another poll. The reverse ordering is also covered, with the doorbell present long before the payload completes and with the payload complete before the doorbell. In those cases the bench confirms that nothing is written until the second condition arrives.

// File: rtl/mbx_ack_pkg.sv
package mbx_ack_pkg;

   typedef enum logic [2:0] {
      ST_POLL_REQ  = 3'd0,
      ST_POLL_WAIT = 3'd1,
      ST_CMD_REQ   = 3'd2,
      ST_CMD_WAIT  = 3'd3,
      ST_WR_CMD    = 3'd4,
      ST_WR_FLAG   = 3'd5,
      ST_DONE      = 3'd6
   } seq_state_e;

   function automatic logic is_read_state(seq_state_e s);
      return (s == ST_POLL_REQ) || (s == ST_CMD_REQ);
   endfunction

   function automatic logic is_write_state(seq_state_e s);
      return (s == ST_WR_CMD) || (s == ST_WR_FLAG);
   endfunction

endpackage

// File: rtl/mbx_ack_fsm.sv
module mbx_ack_fsm
   import mbx_ack_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int DOORBELL_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              payload_ok,
   output seq_state_e        state,
   output logic [DATA_W-1:0] cmd_q,
   output logic              ack_fire,
   output logic              done
);

   seq_state_e nxt;
   logic       go_ack;

   // both conditions judged in the cycle the poll response is valid
   assign go_ack = rd_data[DOORBELL_BIT] && payload_ok;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_POLL_REQ:  nxt = ST_POLL_WAIT;
         ST_POLL_WAIT: if (rd_valid) nxt = go_ack ? ST_CMD_REQ : ST_POLL_REQ;
         ST_CMD_REQ:   nxt = ST_CMD_WAIT;
         ST_CMD_WAIT:  if (rd_valid) nxt = ST_WR_CMD;
         ST_WR_CMD:    nxt = ST_WR_FLAG;
         ST_WR_FLAG:   nxt = ST_DONE;
         ST_DONE:      nxt = ST_DONE;
         default:      nxt = ST_POLL_REQ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_POLL_REQ;
         cmd_q <= '0;
      end else begin
         state <= nxt;
         if (state == ST_CMD_WAIT && rd_valid) cmd_q <= rd_data;
      end
   end

   assign ack_fire = (state == ST_WR_FLAG);
   assign done     = (state == ST_DONE);

   // R7: terminal state is never left
   p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   // R2: a poll waits for its response before anything else happens
   p_poll_waits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_POLL_WAIT && !rd_valid) |=> state == ST_POLL_WAIT);

   // R5: the captured command is frozen while it is being echoed
   p_cmd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WR_CMD || state == ST_WR_FLAG) |=> $stable(cmd_q));

endmodule

// File: rtl/mbx_ack_port.sv
module mbx_ack_port
   import mbx_ack_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 32,
   parameter int OWN_CMD_OFF   = 'h00,
   parameter int PEER_CMD_OFF  = 'h10,
   parameter int OWN_FLAG_OFF  = 'h20,
   parameter int PEER_FLAG_OFF = 'h30,
   parameter int ACK_VALUE     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  seq_state_e        state,
   input  logic [DATA_W-1:0] cmd_q,
   output logic              rd_en,
   output logic              wr_en,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wr_data
);

   localparam logic [ADDR_W-1:0] A_OWN_CMD   = ADDR_W'(OWN_CMD_OFF);
   localparam logic [ADDR_W-1:0] A_PEER_CMD  = ADDR_W'(PEER_CMD_OFF);
   localparam logic [ADDR_W-1:0] A_OWN_FLAG  = ADDR_W'(OWN_FLAG_OFF);
   localparam logic [ADDR_W-1:0] A_PEER_FLAG = ADDR_W'(PEER_FLAG_OFF);
   localparam logic [DATA_W-1:0] ACK_WORD    = DATA_W'(ACK_VALUE);

   always_comb begin
      addr    = '0;
      wr_data = '0;
      unique case (state)
         ST_POLL_REQ, ST_POLL_WAIT: addr = A_PEER_FLAG;
         ST_CMD_REQ, ST_CMD_WAIT:   addr = A_PEER_CMD;
         ST_WR_CMD: begin
            addr    = A_OWN_CMD;
            wr_data = cmd_q;
         end
         ST_WR_FLAG: begin
            addr    = A_OWN_FLAG;
            wr_data = ACK_WORD;
         end
         default: addr = '0;
      endcase
   end

   assign rd_en = rst_n && is_read_state(state);
   assign wr_en = rst_n && is_write_state(state);

   // R6: one shared address bus, never both directions at once
   p_rw_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && wr_en));

   p_rd_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (addr == A_PEER_FLAG || addr == A_PEER_CMD));

   p_wr_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (addr == A_OWN_CMD || addr == A_OWN_FLAG));

endmodule

// File: rtl/mbx_ack_counter.sv
module mbx_ack_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (inc && cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
   end

   // R7: the count only ever moves by one step
   p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> (cnt == $past(cnt) + CNT_W'(1)));

endmodule

// File: rtl/mbx_ack_sequencer.sv
module mbx_ack_sequencer
   import mbx_ack_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 32,
   parameter int CNT_W         = 8,
   parameter int OWN_CMD_OFF   = 'h00,
   parameter int PEER_CMD_OFF  = 'h10,
   parameter int OWN_FLAG_OFF  = 'h20,
   parameter int PEER_FLAG_OFF = 'h30,
   parameter int DOORBELL_BIT  = 0,
   parameter int ACK_VALUE     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              mbx_rd_en,
   output logic              mbx_wr_en,
   output logic [ADDR_W-1:0] mbx_addr,
   output logic [DATA_W-1:0] mbx_wr_data,
   input  logic [DATA_W-1:0] mbx_rd_data,
   input  logic              mbx_rd_valid,
   input  logic              payload_done,
   output logic              done,
   output logic [CNT_W-1:0]  ack_cnt
);

   localparam int ADDR_SPAN = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] A_OWN_FLAG = ADDR_W'(OWN_FLAG_OFF);

   // elaboration-time parameter checks
   if (DATA_W < 2) begin : g_bad_data_w
      $error("mbx_ack_sequencer: DATA_W must be at least 2");
   end
   if (DOORBELL_BIT < 0 || DOORBELL_BIT >= DATA_W) begin : g_bad_bell
      $error("mbx_ack_sequencer: DOORBELL_BIT outside the data word");
   end
   if (CNT_W < 1) begin : g_bad_cnt_w
      $error("mbx_ack_sequencer: CNT_W must be positive");
   end
   if (OWN_CMD_OFF >= ADDR_SPAN || PEER_CMD_OFF >= ADDR_SPAN ||
       OWN_FLAG_OFF >= ADDR_SPAN || PEER_FLAG_OFF >= ADDR_SPAN) begin : g_bad_off
      $error("mbx_ack_sequencer: register offset does not fit ADDR_W");
   end
   if (PEER_FLAG_OFF == PEER_CMD_OFF || OWN_FLAG_OFF == OWN_CMD_OFF) begin : g_alias_off
      $error("mbx_ack_sequencer: flag and command offsets alias");
   end
   if (ACK_VALUE == 0) begin : g_bad_ack
      $error("mbx_ack_sequencer: ACK_VALUE must be non-zero");
   end

   seq_state_e        state;
   logic [DATA_W-1:0] cmd_q;
   logic              ack_fire;

   mbx_ack_fsm #(
      .DATA_W       (DATA_W),
      .DOORBELL_BIT (DOORBELL_BIT)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_valid   (mbx_rd_valid),
      .rd_data    (mbx_rd_data),
      .payload_ok (payload_done),
      .state      (state),
      .cmd_q      (cmd_q),
      .ack_fire   (ack_fire),
      .done       (done)
   );

   mbx_ack_port #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .OWN_CMD_OFF   (OWN_CMD_OFF),
      .PEER_CMD_OFF  (PEER_CMD_OFF),
      .OWN_FLAG_OFF  (OWN_FLAG_OFF),
      .PEER_FLAG_OFF (PEER_FLAG_OFF),
      .ACK_VALUE     (ACK_VALUE)
   ) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .state   (state),
      .cmd_q   (cmd_q),
      .rd_en   (mbx_rd_en),
      .wr_en   (mbx_wr_en),
      .addr    (mbx_addr),
      .wr_data (mbx_wr_data)
   );

   mbx_ack_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ack_fire),
      .cnt   (ack_cnt)
   );

   // R4: nothing is written before the payload has landed
   p_no_write_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mbx_wr_en |-> payload_done);

   // R7: count is zero before done and frozen after it
   p_cnt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ack_cnt == '0);

   p_cnt_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> $stable(ack_cnt));

   p_quiet_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!mbx_rd_en && !mbx_wr_en));

   // R5: done only follows the acknowledge-flag write
   p_done_after_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(mbx_wr_en && mbx_addr == A_OWN_FLAG));

endmodule

// File: tb/test_mbx_ack_sequencer.sv
module test_mbx_ack_sequencer;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;
   localparam int CNT_W  = 8;
   localparam logic [7:0]  OFF_OWN_CMD   = 8'h00;
   localparam logic [7:0]  OFF_PEER_CMD  = 8'h10;
   localparam logic [7:0]  OFF_OWN_FLAG  = 8'h20;
   localparam logic [7:0]  OFF_PEER_FLAG = 8'h30;
   localparam logic [31:0] ACK_WORD      = 32'h2;

   logic              clk;
   logic              rst_n;
   logic              mbx_rd_en, mbx_wr_en;
   logic [ADDR_W-1:0] mbx_addr;
   logic [DATA_W-1:0] mbx_wr_data;
   logic [DATA_W-1:0] mbx_rd_data;
   logic              mbx_rd_valid;
   logic              payload_done;
   logic              done;
   logic [CNT_W-1:0]  ack_cnt;

   mbx_ack_sequencer i_mbx_ack_sequencer (
      .clk          (clk),
      .rst_n        (rst_n),
      .mbx_rd_en    (mbx_rd_en),
      .mbx_wr_en    (mbx_wr_en),
      .mbx_addr     (mbx_addr),
      .mbx_wr_data  (mbx_wr_data),
      .mbx_rd_data  (mbx_rd_data),
      .mbx_rd_valid (mbx_rd_valid),
      .payload_done (payload_done),
      .done         (done),
      .ack_cnt      (ack_cnt)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   // controls written only by the main process (at posedge + 1)
   logic [31:0] peer_flag = '0;
   logic [31:0] peer_cmd  = '0;
   bit          pl_cmd    = 1'b0;
   int          lat       = 1;
   int          race_poll = 0;

   // mailbox model state written only by the responder
   int          cyc = 0;
   int          polls = 0, cmd_reads = 0, wr_n = 0, act_done = 0;
   int          viol_rw = 0, viol_overlap = 0;
   bit          pend = 1'b0, race_hit = 1'b0;
   int          cd = 0;
   logic [7:0]  pa = '0;
   logic [7:0]  wr_a [0:63];
   logic [31:0] wr_d [0:63];
   int          wr_c [0:63];

   int n_chk = 0, n_bad = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // mailbox responder: samples requests at negedge, answers after lat cycles
   always @(negedge clk) begin
      if (!rst_n) begin
         mbx_rd_valid = 1'b0;
         mbx_rd_data  = '0;
         pend         = 1'b0;
         race_hit     = 1'b0;
         payload_done = pl_cmd;
         if (mbx_rd_en || mbx_wr_en) viol_rw++;
      end else begin
         mbx_rd_valid = 1'b0;
         if (pend) begin
            cd--;
            if (cd == 0) begin
               pend         = 1'b0;
               mbx_rd_valid = 1'b1;
               mbx_rd_data  = (pa == OFF_PEER_FLAG) ? peer_flag :
                              (pa == OFF_PEER_CMD)  ? peer_cmd  : 32'hBAD0_BAD0;
               if (pa == OFF_PEER_FLAG && race_poll != 0 && polls == race_poll)
                  race_hit = 1'b1;
            end
         end
         if (mbx_rd_en) begin
            if (pend) viol_overlap++;
            if (mbx_wr_en) viol_rw++;
            if (mbx_addr != OFF_PEER_FLAG && mbx_addr != OFF_PEER_CMD) viol_rw++;
            pend = 1'b1;
            cd   = lat;
            pa   = mbx_addr;
            if (mbx_addr == OFF_PEER_FLAG) polls++;
            else if (mbx_addr == OFF_PEER_CMD) cmd_reads++;
            if (done) act_done++;
         end
         if (mbx_wr_en) begin
            if (mbx_addr != OFF_OWN_CMD && mbx_addr != OFF_OWN_FLAG) viol_rw++;
            wr_a[wr_n & 63] = mbx_addr;
            wr_d[wr_n & 63] = mbx_wr_data;
            wr_c[wr_n & 63] = cyc;
            wr_n++;
            if (done) act_done++;
         end
         payload_done = pl_cmd | race_hit;
      end
   end

   function automatic bit should_ack(logic [31:0] flag, bit pl);
      return flag[0] & pl;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      race_poll = 0;
      rst_n = 1'b0;
      tick(3);
      rst_n = 1'b1;
      #1;
   endtask

   // checks the echo pair starting at log index b
   task automatic chk_echo(input string req, input int b, input logic [31:0] cmd);
      chk(req, "first write addr",  64'(wr_a[b & 63]), 64'(OFF_OWN_CMD));
      chk(req, "first write data",  64'(wr_d[b & 63]), 64'(cmd));
      chk(req, "second write addr", 64'(wr_a[(b+1) & 63]), 64'(OFF_OWN_FLAG));
      chk(req, "second write data", 64'(wr_d[(b+1) & 63]), 64'(ACK_WORD));
      chk(req, "writes adjacent",   64'(wr_c[(b+1) & 63] - wr_c[b & 63]), 64'd1);
   endtask

   task automatic run_pair(input logic [31:0] cmd, input int l, input bit pl_first,
                           input logic [31:0] rnd, input int wait_n);
      int b_p, b_c, b_w, b_d, pc;
      peer_cmd = cmd; lat = l; peer_flag = '0; pl_cmd = 1'b0;
      do_reset();
      b_p = polls; b_c = cmd_reads; b_w = wr_n; b_d = act_done;
      if (pl_first) begin
         pl_cmd = 1'b1; peer_flag = rnd & ~32'h1;
      end else begin
         peer_flag = rnd | 32'h1;
      end
      tick(wait_n);
      if (pl_first) begin
         chk("R4", "ack_cnt no doorbell", 64'(ack_cnt), 64'(should_ack(peer_flag, pl_cmd)));
         chk("R4", "writes no doorbell",  64'(wr_n - b_w), 64'd0);
      end else begin
         chk("R3", "ack_cnt no payload",  64'(ack_cnt), 64'(should_ack(peer_flag, pl_cmd)));
         chk("R3", "writes no payload",   64'(wr_n - b_w), 64'd0);
         chk("R3", "done no payload",     64'(done), 64'd0);
      end
      chk("R2", "keeps polling", 64'((polls - b_p) >= 2), 64'd1);
      if (pl_first) peer_flag = peer_flag | 32'h1;
      else          pl_cmd = 1'b1;
      tick(40);
      chk("R8", "done after both", 64'(done), 64'(should_ack(peer_flag, pl_cmd)));
      chk("R5", "ack_cnt", 64'(ack_cnt), 64'd1);
      chk("R5", "write count", 64'(wr_n - b_w), 64'd2);
      chk("R5", "cmd reads", 64'(cmd_reads - b_c), 64'd1);
      chk_echo("R5", b_w, cmd);
      pc = polls;
      tick(20);
      chk("R7", "no polls after done", 64'(polls - pc), 64'd0);
      chk("R7", "no requests in done", 64'(act_done - b_d), 64'd0);
      chk("R7", "count holds", 64'(ack_cnt), 64'd1);
      chk("R7", "done holds", 64'(done), 64'd1);
   endtask

   initial begin
      int seed_init;
      int b_p, b_w;
      seed_init = $urandom(32'h5EED_0042);
      rst_n = 1'b0;
      tick(4);
      // R1 reset state
      chk("R1", "done in reset",  64'(done), 64'd0);
      chk("R1", "cnt in reset",   64'(ack_cnt), 64'd0);
      chk("R1", "rd_en in reset", 64'(mbx_rd_en), 64'd0);
      chk("R1", "wr_en in reset", 64'(mbx_wr_en), 64'd0);
      rst_n = 1'b1;
      #1;
      chk("R1", "first poll", 64'(mbx_rd_en), 64'd1);
      chk("R1", "first poll addr", 64'(mbx_addr), 64'(OFF_PEER_FLAG));

      // directed: doorbell long before payload, then payload before doorbell
      run_pair(32'hDEAD_C0DE, 1, 1'b0, 32'h0000_0001, 30);
      run_pair(32'h1234_5678, 3, 1'b1, 32'hFFFF_FFFE, 25);

      // directed race (R9): payload rises with the third doorbell response
      peer_cmd = 32'hA5A5_0F0F; lat = 2; peer_flag = 32'h1; pl_cmd = 1'b0;
      do_reset();
      b_p = polls; b_w = wr_n;
      race_poll = polls + 3;
      tick(60);
      chk("R9", "polls before fetch", 64'(polls - b_p), 64'd3);
      chk("R9", "done", 64'(done), 64'd1);
      chk("R9", "ack_cnt", 64'(ack_cnt), 64'd1);
      chk_echo("R9", b_w, 32'hA5A5_0F0F);

      // constrained random mix of orders, latencies and words
      for (int k = 0; k < 8; k++) begin
         run_pair($urandom, 1 + int'($urandom % 3), bit'($urandom % 2),
                  $urandom, 10 + int'($urandom % 20));
      end

      chk("R6", "port violations", 64'(viol_rw), 64'd0);
      chk("R2", "overlapping reads", 64'(viol_overlap), 64'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
      $finish;
   end

endmodule